// File: doc/BRIEF.md
# Half-Pel Pixel Interpolator Register Slave

This block is a memory-mapped slave that turns one half-pel interpolation into a few register accesses. Software stores up to four 8-bit neighbouring samples and a one-bit rounding control in word registers. It then reads one of two computed addresses. One returns the rounded mean of two samples and the other returns the rounded mean of all four. The rounding bit is subtracted before the shift, so the encoder can choose how ties are resolved.

The port is a 32-bit, word-addressed register interface: select, write enable, byte address, write data, read data and ready. It can sit behind an AHB-style slave adapter. Only address bits [4:2] choose the register. Writes complete in the cycle they are presented. A read request is captured at the clock edge and its data appears on the read bus in the following cycle, where it stays until the next read. Each interpolated pixel costs one transaction, and the block runs no sequencing of its own.

Top module: `halfpel_interp`

## Requirements
- R1: After reset, the stored samples and the rounding bit are zero, and the read data output is zero.
- R2: A write to offset 0x00, 0x04, 0x08 or 0x0C (samples a, b, c, d) stores write-data bits [7:0] and ignores all higher bits. Reading the same offset returns the stored byte zero-extended to 32 bits.
- R3: A write to offset 0x10 stores only write-data bit 0 as the rounding bit r. Reading 0x10 returns r in bit 0, with all other bits zero.
- R4: A read at offset 0x14 returns (a + b + 1 − r) >> 1 in bits [7:0], with bits [31:8] zero.
- R5: A read at offset 0x18 returns (a + b + c + d + 2 − r) >> 2 in bits [7:0], with bits [31:8] zero. The sum is formed without overflow, so four samples of 255 with r = 0 give 255.
- R6: A read at offset 0x1C returns zero. Writes to 0x14, 0x18 and 0x1C change no stored value.
- R7: Only address bits [4:2] select the register. Bits [1:0] and bits above bit 4 have no effect on reads or writes.
- R8: The read data for a request accepted at a clock edge is on the read bus through the next cycle. The read bus holds its value across idle cycles and writes until the next read is accepted.
- R9: Ready is high in every cycle after reset, and a write or read never stalls.
- R10: A write presented while select is low changes no stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select for the current transfer |
| we_i | input | 1 | Write enable: 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Byte address; bits [4:2] choose the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ready_o | output | 1 | Transfer complete; always high |

## Verification
The assertions assume a few things about the inputs. Select and write enable are known, 0 or 1, at every clock edge after reset. The address carries at least bits [4:2]. The samples held in the registers are 8-bit values, so the average bounds the assertions check follow from that width alone. The stimulus stays within these limits: every control input is driven to a defined level on the falling edge, and addresses are formed from a random register index plus random bits above bit 4 and in bits [1:0]. Directed cases cover all-zero and all-255 samples with both rounding values.

// File: rtl/interp_pkg.sv
package interp_pkg;

    parameter int PIX_W = 8;
    parameter int SUM_W = PIX_W + 2;

    typedef enum logic [2:0] {
        IDX_A    = 3'd0,
        IDX_B    = 3'd1,
        IDX_C    = 3'd2,
        IDX_D    = 3'd3,
        IDX_R    = 3'd4,
        IDX_AVG2 = 3'd5,
        IDX_AVG4 = 3'd6,
        IDX_NONE = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [PIX_W-1:0] a;
        logic [PIX_W-1:0] b;
        logic [PIX_W-1:0] c;
        logic [PIX_W-1:0] d;
        logic             r;
    } sample_s;

endpackage

// File: rtl/interp_regs.sv
module interp_regs
    import interp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_idx_e         idx,
    input  logic [PIX_W-1:0] wbyte,
    output sample_s          smp_o
);

    sample_s smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (wr_en) begin
            case (idx)
                IDX_A:   smp_d.a = wbyte;
                IDX_B:   smp_d.b = wbyte;
                IDX_C:   smp_d.c = wbyte;
                IDX_D:   smp_d.d = wbyte;
                IDX_R:   smp_d.r = wbyte[0];
                default: smp_d = smp_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign smp_o = smp_q;

    AST_WR_SAMPLE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_A) |=> (smp_o.a == $past(wbyte))); // R2
    AST_WR_SAMPLE_D: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_D) |=> (smp_o.d == $past(wbyte))); // R2
    AST_WR_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_R) |=> (smp_o.r == $past(wbyte[0]))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(smp_o)); // R10

endmodule

// File: rtl/interp_avg.sv
module interp_avg
    import interp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sample_s          smp,
    output logic [PIX_W-1:0] avg2_o,
    output logic [PIX_W-1:0] avg4_o
);

    logic [SUM_W-1:0] sum2, sum4;

    always_comb begin
        sum2 = SUM_W'(smp.a) + SUM_W'(smp.b) + SUM_W'(1) - SUM_W'(smp.r);
        sum4 = SUM_W'(smp.a) + SUM_W'(smp.b) + SUM_W'(smp.c) + SUM_W'(smp.d)
             + SUM_W'(2) - SUM_W'(smp.r);
        avg2_o = sum2[PIX_W:1];
        avg4_o = sum4[PIX_W+1:2];
    end

    logic [PIX_W-1:0] lo2, hi2, lo4, hi4;
    always_comb begin
        lo2 = (smp.a < smp.b) ? smp.a : smp.b;
        hi2 = (smp.a < smp.b) ? smp.b : smp.a;
        lo4 = lo2;
        hi4 = hi2;
        if (smp.c < lo4) lo4 = smp.c;
        if (smp.d < lo4) lo4 = smp.d;
        if (smp.c > hi4) hi4 = smp.c;
        if (smp.d > hi4) hi4 = smp.d;
    end

    AST_AVG2_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (avg2_o >= lo2) && (avg2_o <= hi2)); // R4
    AST_AVG4_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (avg4_o >= lo4) && (avg4_o <= hi4)); // R5

endmodule

// File: rtl/halfpel_interp.sv
module halfpel_interp
    import interp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ready_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_s;

    reg_idx_e         idx;
    logic             wr_en;
    logic             rd_en;
    sample_s          smp;
    logic [PIX_W-1:0] avg2, avg4;
    rd_state_s        st_d, st_q;
    logic             unused_bits;

    assign idx         = reg_idx_e'(addr_i[4:2]);
    assign wr_en       = sel_i && we_i && (idx <= IDX_R);
    assign rd_en       = sel_i && !we_i;
    assign unused_bits = ^{addr_i[ADDR_W-1:5], addr_i[1:0], wdata_i[DATA_W-1:PIX_W]};

    interp_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .idx   (idx),
        .wbyte (wdata_i[PIX_W-1:0]),
        .smp_o (smp)
    );

    interp_avg u_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp    (smp),
        .avg2_o (avg2),
        .avg4_o (avg4)
    );

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            case (idx)
                IDX_A:    st_d.rdata = DATA_W'(smp.a);
                IDX_B:    st_d.rdata = DATA_W'(smp.b);
                IDX_C:    st_d.rdata = DATA_W'(smp.c);
                IDX_D:    st_d.rdata = DATA_W'(smp.d);
                IDX_R:    st_d.rdata = DATA_W'(smp.r);
                IDX_AVG2: st_d.rdata = DATA_W'(avg2);
                IDX_AVG4: st_d.rdata = DATA_W'(avg4);
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign ready_o = 1'b1;

    AST_RD_AVG2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == IDX_AVG2) |=> (rdata_o == DATA_W'($past(avg2)))); // R4
    AST_RD_AVG4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == IDX_AVG4) |=> (rdata_o == DATA_W'($past(avg4)))); // R5
    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == IDX_NONE) |=> (rdata_o == '0)); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_o)); // R8

endmodule

// File: tb/tb_halfpel_interp.sv
`timescale 1ns/1ps
module tb_halfpel_interp;

    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_i = 1'b0;
    logic              we_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic              ready_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] m_a = 0, m_b = 0, m_c = 0, m_d = 0;
    logic       m_r = 0;

    always #2 clk = ~clk;

    halfpel_interp #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ready_o(ready_o)
    );

    function automatic logic [31:0] exp_avg2();
        int s = int'(m_a) + int'(m_b) + 1 - int'(m_r);
        return 32'(s >> 1);
    endfunction

    function automatic logic [31:0] exp_avg4();
        int s = int'(m_a) + int'(m_b) + int'(m_c) + int'(m_d) + 2 - int'(m_r);
        return 32'(s >> 2);
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] idx);
        case (idx)
            3'd0: return {24'd0, m_a};
            3'd1: return {24'd0, m_b};
            3'd2: return {24'd0, m_c};
            3'd3: return {24'd0, m_d};
            3'd4: return {31'd0, m_r};
            3'd5: return exp_avg2();
            3'd6: return exp_avg4();
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [2:0] idx, input bit scramble);
        logic [ADDR_W-1:0] a = '0;
        a[4:2] = idx;
        if (scramble) begin
            a[1:0] = 2'($urandom);
            a[ADDR_W-1:5] = (ADDR_W-5)'($urandom);
        end
        return a;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic do_write(input logic [2:0] idx, input logic [31:0] data, input bit scramble,
                            input bit selected);
        sel_i = selected; we_i = 1'b1; addr_i = mk_addr(idx, scramble); wdata_i = data;
        @(negedge clk);
        sel_i = 1'b0; we_i = 1'b0; wdata_i = 32'($urandom);
        if (selected) begin
            case (idx)
                3'd0: m_a = data[7:0];
                3'd1: m_b = data[7:0];
                3'd2: m_c = data[7:0];
                3'd3: m_d = data[7:0];
                3'd4: m_r = data[0];
                default: ;
            endcase
        end
    endtask

    task automatic do_read(input logic [2:0] idx, input bit scramble, input string req);
        logic [31:0] e = exp_read(idx);
        sel_i = 1'b1; we_i = 1'b0; addr_i = mk_addr(idx, scramble);
        @(negedge clk);
        sel_i = 1'b0;
        check(req, rdata_o, e);
    endtask

    task automatic load_all(input logic [7:0] a, b, c, d, input logic r);
        do_write(3'd0, {24'hA5A5A5, a}, 1'b0, 1'b1);
        do_write(3'd1, {24'h5A5A5A, b}, 1'b0, 1'b1);
        do_write(3'd2, {24'hFFFFFF, c}, 1'b0, 1'b1);
        do_write(3'd3, {24'h123456, d}, 1'b0, 1'b1);
        do_write(3'd4, {31'h7FFFFFFE, r}, 1'b0, 1'b1);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata after reset", rdata_o, 32'd0);
        check("R9 ready in reset", {31'd0, ready_o}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) do_read(3'(i), 1'b0, "R1 register reset value");

        // R2/R3: upper bits dropped, zero-extended readback
        load_all(8'h3C, 8'hC3, 8'h01, 8'hFE, 1'b1);
        for (int i = 0; i < 4; i++) do_read(3'(i), 1'b0, "R2 sample readback");
        do_read(3'd4, 1'b0, "R3 rounding bit readback");

        // R4/R5 corner: all 255
        load_all(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0);
        do_read(3'd5, 1'b0, "R4 avg2 all-255 r=0");
        do_read(3'd6, 1'b0, "R5 avg4 all-255 r=0");
        check("R5 avg4 max literal", rdata_o, 32'd255);
        do_write(3'd4, 32'd1, 1'b0, 1'b1);
        do_read(3'd5, 1'b0, "R4 avg2 all-255 r=1");
        do_read(3'd6, 1'b0, "R5 avg4 all-255 r=1");
        // all zero with rounding 1
        load_all(8'h00, 8'h00, 8'h00, 8'h00, 1'b1);
        do_read(3'd5, 1'b0, "R4 avg2 zero r=1");
        do_read(3'd6, 1'b0, "R5 avg4 zero r=1");
        // tie case: 1 and 2
        load_all(8'd1, 8'd2, 8'd3, 8'd4, 1'b0);
        do_read(3'd5, 1'b0, "R4 avg2 tie r=0");
        check("R4 avg2 tie literal", rdata_o, 32'd2);
        do_write(3'd4, 32'd1, 1'b0, 1'b1);
        do_read(3'd5, 1'b0, "R4 avg2 tie r=1");
        check("R4 avg2 tie r=1 literal", rdata_o, 32'd1);

        // R6: unmapped read and ignored writes
        do_read(3'd7, 1'b0, "R6 unmapped read");
        do_write(3'd5, 32'hFFFF_FFFF, 1'b0, 1'b1);
        do_write(3'd6, 32'hFFFF_FFFF, 1'b0, 1'b1);
        do_write(3'd7, 32'hFFFF_FFFF, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) do_read(3'(i), 1'b0, "R6 writes to computed offsets ignored");

        // R10: unselected writes ignored
        for (int i = 0; i < 5; i++) do_write(3'(i), 32'hFFFF_FFFF, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) do_read(3'(i), 1'b0, "R10 unselected write ignored");

        // R8: read data held across idle and writes
        do_read(3'd6, 1'b0, "R8 capture");
        held = rdata_o;
        repeat (3) @(negedge clk);
        do_write(3'd0, 32'h77, 1'b0, 1'b1);
        check("R8 hold across idle and write", rdata_o, held);

        // R7 + random: scrambled address bits
        for (int n = 0; n < 400; n++) begin
            logic [2:0] idx = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 0)
                do_write(idx, $urandom, 1'b1, 1'b1);
            else
                do_read(idx, 1'b1, "R7 random access with aliased address");
            check("R9 ready always high", {31'd0, ready_o}, 32'd1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule